// File: doc/BRIEF.md
# GPIO Input Conditioning Router

This block conditions a bank of 28 general-purpose input pins before software or the interrupt logic sees them. Each raw pin is first brought into the slow (32 kHz) clock domain through a two-flop synchronizer. A pool of eight conditioning slots is shared by all pins. Each slot holds a programmable debounce filter and a rising-edge event counter. A per-slot select value names the pin that the slot serves.

For every pin, the conditioned level comes from the serving slot when one exists and that pin has its filter or count enable set. Otherwise it comes straight from the synchronized pin. The conditioned level is registered as the pin's read-back value. A per-pin edge detector watches that level and raises a sticky event flag on a rising transition, a falling transition or both, as chosen by the pin's enables. The flags are collected into one interrupt request line. Configuration arrives as plain input vectors; no register decoding is done here.

Top module: `gpio_cond_router`

## Requirements
- R1: A pin not served by any slot shows a change of its raw input at `readback` exactly three clock edges after the change: two synchronizer stages plus the output register.
- R2: Slot s serves pin p when its 5-bit select field `slot_sel[5s+4:5s]` equals p and pin p has its filter or count enable set. A select value of 28 or more serves no pin. A pin with enables set but no slot selecting it uses the unserved path of R1.
- R3: With the filter enabled and a filter amount A, a raw level change that is held appears at `readback` exactly A+4 edges after the change. With A = 0 it appears after 4 edges.
- R4: With the filter enabled, a raw pulse that stays for A cycles or fewer, with A > 0, never reaches `readback`.
- R5: When two slots select the same served pin, the lower-numbered slot determines that pin's conditioned value.
- R6: Filter and count enables for pins 0 to 15 come from bit i of `flt_en_lo`/`evt_en_lo`. Those for pins 16 to 27 come from bit p-16 of `flt_en_hi`/`evt_en_hi`.
- R7: `edge_flag[p]` is set on the same edge that `readback[p]` goes 0 to 1 when `pos_en[p]` is high, and on the edge that it goes 1 to 0 when `neg_en[p]` is high. A transition whose enable is low sets nothing.
- R8: An edge flag stays set until a one-cycle `edge_clr[p]` strobe clears it. A new edge event in the same cycle as the clear leaves the flag set.
- R9: `irq` is high exactly when at least one edge flag is set, and it is updated on the same edge as the flags.
- R10: A served slot whose pin has its count enable set counts rising transitions of the synchronized pin in its 16-bit field of `evt_count` (slot s at bits 16s+15:16s), wrapping at 2^16. It holds its count while the count enable is low. A slot without filter enable passes the synchronized pin level through unchanged.
- R11: Synchronous reset clears `readback`, `edge_flag`, `irq`, all event counts, the filter state and the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow conditioning clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 28 | Asynchronous raw pin levels |
| slot_sel | input | 40 | Per-slot pin select, 5 bits per slot |
| slot_amount | input | 128 | Per-slot filter amount, 16 bits per slot |
| flt_en_lo | input | 16 | Filter enables, pins 0 to 15 |
| flt_en_hi | input | 12 | Filter enables, pins 16 to 27 |
| evt_en_lo | input | 16 | Count enables, pins 0 to 15 |
| evt_en_hi | input | 12 | Count enables, pins 16 to 27 |
| pos_en | input | 28 | Per-pin rising-edge detect enable |
| neg_en | input | 28 | Per-pin falling-edge detect enable |
| edge_clr | input | 28 | Per-pin one-cycle flag clear strobe |
| readback | output | 28 | Registered conditioned pin levels |
| edge_flag | output | 28 | Sticky per-pin edge event flags |
| irq | output | 1 | OR of all edge flags, registered |
| evt_count | output | 128 | Per-slot event counts, 16 bits per slot |

## Verification
The bench sweeps the filter amount from 0 to 4. At each amount it checks the last cycle where the old level still shows and the first cycle where the new one appears. An off-by-one in the down-counter would show up one edge early or late, and a filter that rolled over from zero would stall. Pulses exactly as long as the amount are sent to catch a counter that accepts a glitch. Each of the 28 pins is toggled alone to catch a misrouted bank split or a pin mapped to the wrong index. Two slots are made to fight over one pin to expose a priority that favours the higher slot. A clear strobe is made to land on the same edge as a new event to catch a clear that swallows an edge.

// File: rtl/gpio_cond_pkg.sv
package gpio_cond_pkg;
  // Width of the lower enable bank; the upper bank takes the remaining pins.
  localparam int LO_BANK_W = 16;
endpackage

// File: rtl/cond_sync.sv
module cond_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cond_filter.sv
module cond_filter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] amount,
  input  logic             din,
  output logic             dout
);
  logic [CNT_W-1:0] cnt;

  // Counter reloads while input matches output; on mismatch it counts down
  // and only transfers the new level once it has reached zero (no wrap).
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      dout <= 1'b0;
    end else if (en) begin
      if (din == dout) begin
        cnt <= amount;
      end else if (cnt == '0) begin
        dout <= din;
        cnt  <= amount;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cond_evtcnt.sv
module cond_evtcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             din,
  output logic [CNT_W-1:0] count
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b0;
      count <= '0;
    end else begin
      prev <= din;
      if (en && din && !prev) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_cond_router.sv
module gpio_cond_router
  import gpio_cond_pkg::*;
#(
  parameter int NUM_PINS    = 28,
  parameter int NUM_SLOTS   = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_PINS),
  localparam int HI_W       = NUM_PINS - LO_BANK_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        pin_raw,
  input  logic [NUM_SLOTS*SEL_W-1:0] slot_sel,
  input  logic [NUM_SLOTS*CNT_W-1:0] slot_amount,
  input  logic [LO_BANK_W-1:0]       flt_en_lo,
  input  logic [HI_W-1:0]            flt_en_hi,
  input  logic [LO_BANK_W-1:0]       evt_en_lo,
  input  logic [HI_W-1:0]            evt_en_hi,
  input  logic [NUM_PINS-1:0]        pos_en,
  input  logic [NUM_PINS-1:0]        neg_en,
  input  logic [NUM_PINS-1:0]        edge_clr,
  output logic [NUM_PINS-1:0]        readback,
  output logic [NUM_PINS-1:0]        edge_flag,
  output logic                       irq,
  output logic [NUM_SLOTS*CNT_W-1:0] evt_count
);
  logic [NUM_PINS-1:0]  pin_sync, flt_en, evt_en, pin_used, cond, flag_nxt;
  logic [NUM_SLOTS-1:0] slot_in, slot_flt, slot_evt, filt_q, slot_out;

  assign flt_en   = {flt_en_hi, flt_en_lo};
  assign evt_en   = {evt_en_hi, evt_en_lo};
  assign pin_used = flt_en | evt_en;

  cond_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_raw), .q(pin_sync)
  );

  // Shared conditioning slots: each one taps the pin its select names.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [SEL_W-1:0] sel;
    logic             sel_ok;
    assign sel         = slot_sel[s*SEL_W +: SEL_W];
    assign sel_ok      = int'(sel) < NUM_PINS;
    assign slot_in[s]  = sel_ok ? pin_sync[sel] : 1'b0;
    assign slot_flt[s] = sel_ok & flt_en[sel];
    assign slot_evt[s] = sel_ok & evt_en[sel];

    cond_filter #(.CNT_W(CNT_W)) u_flt (
      .clk(clk), .rst(rst), .en(slot_flt[s]),
      .amount(slot_amount[s*CNT_W +: CNT_W]),
      .din(slot_in[s]), .dout(filt_q[s])
    );

    cond_evtcnt #(.CNT_W(CNT_W)) u_evt (
      .clk(clk), .rst(rst), .en(slot_evt[s]),
      .din(slot_in[s]), .count(evt_count[s*CNT_W +: CNT_W])
    );

    assign slot_out[s] = slot_flt[s] ? filt_q[s] : slot_in[s];
  end

  // Per-pin source choice; scanning downward lets the lowest slot win.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic cv;
    always_comb begin
      cv = pin_sync[p];
      for (int s = NUM_SLOTS-1; s >= 0; s--) begin
        if (pin_used[p] && slot_sel[s*SEL_W +: SEL_W] == SEL_W'(p)) cv = slot_out[s];
      end
    end
    assign cond[p] = cv;
  end

  assign flag_nxt = (edge_flag & ~edge_clr)
                  | (pos_en &  cond & ~readback)
                  | (neg_en & ~cond &  readback);

  always_ff @(posedge clk) begin
    if (rst) begin
      readback  <= '0;
      edge_flag <= '0;
      irq       <= 1'b0;
    end else begin
      readback  <= cond;
      edge_flag <= flag_nxt;
      irq       <= |flag_nxt;
    end
  end
endmodule

// File: rtl/gpio_cond_router_chk.sv
module gpio_cond_router_chk #(
  parameter int NUM_PINS  = 28,
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W     = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_PINS-1:0]        edge_clr,
  input logic [NUM_PINS-1:0]        readback,
  input logic [NUM_PINS-1:0]        edge_flag,
  input logic                       irq,
  input logic [NUM_SLOTS*CNT_W-1:0] evt_count
);
  // R8: a set flag not hit by a clear strobe is still set next cycle
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    1 |=> ((($past(edge_flag) & ~$past(edge_clr)) & ~edge_flag) == '0));

  // R9: interrupt line mirrors the flag vector
  a_r9_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    1 |-> (irq == (|edge_flag)));

  // R7: a flag can only rise on a pin whose read-back value just changed
  a_r7_flag_needs_change: assert property (@(posedge clk) disable iff (rst)
    1 |=> (((edge_flag & ~$past(edge_flag)) & ~(readback ^ $past(readback))) == '0));

  // R10: each slot count advances by at most one per cycle
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cnt
    a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
      1 |=> (CNT_W'(evt_count[s*CNT_W +: CNT_W] - $past(evt_count[s*CNT_W +: CNT_W])) <= CNT_W'(1)));
  end
endmodule

bind gpio_cond_router gpio_cond_router_chk #(
  .NUM_PINS(NUM_PINS), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .edge_clr(edge_clr), .readback(readback),
  .edge_flag(edge_flag), .irq(irq), .evt_count(evt_count)
);

// File: tb/gpio_cond_router_test.sv
module gpio_cond_router_test;
  localparam int NP = 28;
  localparam int NS = 8;
  localparam int SW = 5;
  localparam int CW = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NP-1:0]  pin_raw = '0;
  logic [NS*SW-1:0] slot_sel = '1;
  logic [NS*CW-1:0] slot_amount = '0;
  logic [15:0]    flt_en_lo = '0, evt_en_lo = '0;
  logic [11:0]    flt_en_hi = '0, evt_en_hi = '0;
  logic [NP-1:0]  pos_en = '0, neg_en = '0, edge_clr = '0;
  logic [NP-1:0]  readback, edge_flag;
  logic           irq;
  logic [NS*CW-1:0] evt_count;

  int nchk  = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  gpio_cond_router uut (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .slot_sel(slot_sel),
    .slot_amount(slot_amount), .flt_en_lo(flt_en_lo), .flt_en_hi(flt_en_hi),
    .evt_en_lo(evt_en_lo), .evt_en_hi(evt_en_hi), .pos_en(pos_en),
    .neg_en(neg_en), .edge_clr(edge_clr), .readback(readback),
    .edge_flag(edge_flag), .irq(irq), .evt_count(evt_count)
  );

  task automatic stp(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string what, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  task automatic clear_flags();
    edge_clr = '1;
    stp(1);
    edge_clr = '0;
  endtask

  task automatic idle_cfg();
    pin_raw = '0; slot_sel = '1; slot_amount = '0;
    flt_en_lo = '0; flt_en_hi = '0; evt_en_lo = '0; evt_en_hi = '0;
    pos_en = '0; neg_en = '0;
    stp(8);
    clear_flags();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    stp(3);
    // R11: reset state
    check("R11 readback after reset", readback, '0);
    check("R11 flags after reset", edge_flag, '0);
    check("R11 irq after reset", irq, 0);
    check("R11 counts after reset", evt_count, '0);
    rst = 1'b0;
    stp(2);

    // R1 / R7 / R9 / R8 on an unserved pin
    pos_en[3] = 1'b1;
    pin_raw[3] = 1'b1;
    stp(2);
    check("R1 raw path not yet at edge 2", readback[3], 0);
    stp(1);
    check("R1 raw path at edge 3", readback[3], 1);
    check("R7 rising flag", edge_flag[3], 1);
    check("R9 irq with flag", irq, 1);
    stp(5);
    check("R8 flag sticky", edge_flag[3], 1);
    edge_clr[3] = 1'b1;
    stp(1);
    edge_clr[3] = 1'b0;
    check("R8 flag cleared", edge_flag[3], 0);
    check("R9 irq dropped", irq, 0);
    pin_raw[3] = 1'b0;
    stp(4);
    check("R7 falling ignored without neg_en", edge_flag[3], 0);
    pos_en[3] = 1'b0; neg_en[3] = 1'b1;
    pin_raw[3] = 1'b1;
    stp(4);
    check("R7 rising ignored without pos_en", edge_flag[3], 0);
    pin_raw[3] = 1'b0;
    stp(4);
    check("R7 falling flag", edge_flag[3], 1);
    idle_cfg();

    // R1 / R7: every pin alone on the raw path
    pos_en = '1;
    for (int p = 0; p < NP; p++) begin
      pin_raw = NP'(1) << p;
      stp(3);
      check($sformatf("R1 pin %0d readback", p), readback, NP'(1) << p);
      check($sformatf("R7 pin %0d flag", p), edge_flag, NP'(1) << p);
      pin_raw = '0;
      edge_clr = '1;
      stp(1);
      edge_clr = '0;
      stp(3);
      check($sformatf("R1 pin %0d back low", p), readback, '0);
    end
    idle_cfg();

    // R8: clear lands on the same edge as a new event
    pos_en[4] = 1'b1;
    pin_raw[4] = 1'b1;
    stp(2);
    edge_clr[4] = 1'b1;
    stp(1);
    edge_clr[4] = 1'b0;
    check("R8 set wins over clear", edge_flag[4], 1);
    idle_cfg();

    // R3 / R4: filter amount sweep on slot 2 serving pin 5
    for (int a = 0; a <= 4; a++) begin
      slot_sel[2*SW +: SW] = 5'd5;
      slot_amount[2*CW +: CW] = CW'(a);
      flt_en_lo[5] = 1'b1;
      pin_raw = '0;
      stp(6);
      if (a > 0) begin
        pin_raw[5] = 1'b1;
        stp(a);
        pin_raw[5] = 1'b0;
        stp(a + 8);
        check($sformatf("R4 glitch of %0d rejected", a), readback[5], 0);
      end
      pin_raw[5] = 1'b1;
      stp(a + 3);
      check($sformatf("R3 amount %0d not early", a), readback[5], 0);
      stp(1);
      check($sformatf("R3 amount %0d on time", a), readback[5], 1);
      pin_raw[5] = 1'b0;
      stp(a + 6);
      check($sformatf("R3 amount %0d back low", a), readback[5], 0);
    end
    idle_cfg();

    // R6: upper-bank pin 20 on slot 6, amount 5
    slot_sel[6*SW +: SW] = 5'd20;
    slot_amount[6*CW +: CW] = 16'd5;
    flt_en_lo[4] = 1'b1;
    stp(4);
    pin_raw[20] = 1'b1;
    stp(3);
    check("R6 low-bank bit 4 does not filter pin 20", readback[20], 1);
    pin_raw[20] = 1'b0;
    flt_en_lo[4] = 1'b0;
    stp(6);
    flt_en_hi[4] = 1'b1;
    stp(4);
    pin_raw[20] = 1'b1;
    stp(8);
    check("R6 high-bank filter not early", readback[20], 0);
    stp(1);
    check("R6 high-bank filter on time", readback[20], 1);
    idle_cfg();

    // R5: slots 1 and 4 both serve pin 7
    slot_sel[1*SW +: SW] = 5'd7;
    slot_sel[4*SW +: SW] = 5'd7;
    slot_amount[1*CW +: CW] = 16'd6;
    slot_amount[4*CW +: CW] = 16'd0;
    flt_en_lo[7] = 1'b1;
    stp(4);
    pin_raw[7] = 1'b1;
    stp(9);
    check("R5 lower slot governs, not early", readback[7], 0);
    stp(1);
    check("R5 lower slot governs, on time", readback[7], 1);
    idle_cfg();

    // R2: enables set but no slot selects the pin; invalid select values
    slot_sel[0*SW +: SW] = 5'd30;
    slot_amount[0*CW +: CW] = 16'd10;
    flt_en_lo[9] = 1'b1;
    stp(4);
    pin_raw[9] = 1'b1;
    stp(3);
    check("R2 unselected pin uses raw path", readback[9], 1);
    pin_raw[9] = 1'b0;
    flt_en_lo[9] = 1'b0;
    slot_sel[0*SW +: SW] = 5'd9;
    stp(4);
    pin_raw[9] = 1'b1;
    stp(3);
    check("R2 selected pin without enables uses raw path", readback[9], 1);
    idle_cfg();

    // R10: event counting on slot 3 serving pin 12
    slot_sel[3*SW +: SW] = 5'd12;
    evt_en_lo[12] = 1'b1;
    stp(4);
    for (int k = 0; k < 3; k++) begin
      pin_raw[12] = 1'b1;
      stp(2);
      if (k == 0) check("R10 passthrough not early", readback[12], 0);
      stp(1);
      if (k == 0) check("R10 passthrough on time", readback[12], 1);
      stp(1);
      pin_raw[12] = 1'b0;
      stp(4);
    end
    check("R10 three rising edges counted", evt_count[3*CW +: CW], 16'd3);
    check("R10 other slots idle", evt_count[0 +: 3*CW], '0);
    evt_en_lo[12] = 1'b0;
    for (int k = 0; k < 2; k++) begin
      pin_raw[12] = 1'b1;
      stp(4);
      pin_raw[12] = 1'b0;
      stp(4);
    end
    check("R10 count held while disabled", evt_count[3*CW +: CW], 16'd3);

    // R11: reset mid-run
    pos_en = '1;
    pin_raw[1] = 1'b1;
    stp(4);
    rst = 1'b1;
    stp(2);
    check("R11 counts cleared", evt_count, '0);
    check("R11 flags cleared", edge_flag, '0);
    check("R11 readback cleared", readback, '0);
    rst = 1'b0;
    stp(2);

    summary();
    $finish;
  end
endmodule